// File: doc/BRIEF.md
# Permute Bundle Combiner

This block sits in the issue stage. It joins a two-instruction bundle into one four-operand permute request. The first instruction of a bundle is a control instruction, which names two configuration registers. The second is a permute instruction, which names a destination, a data register and a third configuration register. A kind bit marks each of them as forward butterfly or inverse butterfly. The combiner holds the control instruction until its partner arrives. When the partner is a permute of the same kind, both issue in one beat with four register read ports enabled, so the permutation unit gets its data word and all three configuration words together.

Any other instruction flows through unchanged with two read ports. If a control instruction is not followed by a permute of the same kind, it is thrown away and an error strobe fires. Instructions enter on a valid/ready stream and leave on another. A pass-through instruction adds no register stage. Because a bundle issues only when its second half arrives, a fetch rate of one instruction per cycle gives one complete permute every two input beats. A full forward-then-inverse permutation therefore spans four beats.

The input stream obeys these back-pressure rules:
- An input beat is taken only in a cycle where `in_valid` and `in_ready` are both high.
- While `in_valid` is high and `in_ready` is low, the producer must hold `in_insn` steady.
- The issue stream follows the same rules with `iss_valid` and `iss_ready`.

Top module: `perm_bundle_combiner`

## Requirements

Instruction encoding, with `REG_W`=5 (18 bits):

| Bits | Field | Meaning |
|------|-------|---------|
| [17:16] | class | 2'b01 = control, 2'b10 = permute, any other value = ordinary |
| [15] | kind | 0 = forward, 1 = inverse |
| [14:10] | rd | destination register |
| [9:5] | ra | first source register |
| [4:0] | rb | second source register |

- R1: Reset clears the held control instruction and the error strobe. Coming out of reset, `iss_valid` equals `in_valid`, `in_ready` equals `iss_ready`, and a permute arriving straight after reset issues unpaired.
- R2: When no control instruction is held, an ordinary instruction (class 00 or 11) issues in the same cycle with these outputs:
  - `iss_bundle`=0 and `iss_rden`=4'b0011;
  - `iss_rd`=rd, `iss_rs0`=ra, `iss_rs1`=rb, and `iss_rs2`=`iss_rs3`=0.
- R3: When no control instruction is held, a control instruction (class 01) is accepted with `in_ready`=1. It is captured and nothing issues in that cycle.
- R4: A permute (class 10) whose kind matches the held control issues as a bundle in the cycle it arrives. The outputs are:
  - `iss_bundle`=1, `iss_rden`=4'b1111 and `iss_inv`=kind;
  - `iss_rd`=permute rd and `iss_rs0`=permute ra;
  - `iss_rs1`=control ra, `iss_rs2`=control rb and `iss_rs3`=permute rb.
- R5: A permute whose kind differs from the held control's kind does not pair. In that cycle it is refused (`in_ready`=0) and nothing issues.
- R6: A held control followed by any non-matching instruction is discarded. In the cycle after the discard, `orphan_err` is high for exactly one cycle. The refused instruction is then handled as if nothing were held.
- R7: A permute that arrives with no control held issues unpaired (`iss_bundle`=0, two read ports).
- R8: While a bundle is offered and `iss_ready` is low, `in_ready` is 0 and the held control is kept. The same bundle issues once `iss_ready` rises.
- R9: While a control is held and `in_valid` is low, nothing issues, the held control is kept, and no error is raised.
- R10: At one instruction per cycle, two back-to-back bundles take four input beats and issue on the second and fourth beats.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched instruction valid |
| in_ready | output | 1 | Combiner accepts the instruction |
| in_insn | input | 3+3*REG_W | Fetched instruction word |
| iss_valid | output | 1 | Issue request valid |
| iss_ready | input | 1 | Issue stage accepts the request |
| iss_bundle | output | 1 | Request is a paired four-operand permute |
| iss_inv | output | 1 | Kind bit of the request (1 = inverse) |
| iss_insn | output | 3+3*REG_W | Incoming instruction word, unchanged |
| iss_rd | output | REG_W | Destination register |
| iss_rs0 | output | REG_W | Read port 0 register (data / ra) |
| iss_rs1 | output | REG_W | Read port 1 register (config 1 / rb) |
| iss_rs2 | output | REG_W | Read port 2 register (config 2) |
| iss_rs3 | output | REG_W | Read port 3 register (config 3) |
| iss_rden | output | 4 | Read port enables |
| orphan_err | output | 1 | One-cycle strobe: a held control was discarded |

## Verification

The stall property assumes the producer keeps `in_insn` and `in_valid` steady while a beat is refused. The bench rows reflect that: a refused or back-pressured instruction is repeated unchanged in the next row. The other properties assume nothing about the inputs. They tie a bundle issue to a held control of the same kind, tie an error strobe to a refused beat in the cycle before, and tie each capture to an accepted beat that did not issue. The stimulus covers both kinds, a kind mismatch, an ordinary instruction after a control, an idle input while a control is held, a stall on the issue side, and reset with a control held.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'b00,
    CLS_CTL = 2'b01,
    CLS_PRM = 2'b10,
    CLS_RSV = 2'b11
  } insn_cls_e;

  localparam int RD_PORTS   = 4;
  localparam int BASE_PORTS = 2;
endpackage

// File: rtl/pbc_decode.sv
module pbc_decode #(
  parameter int REG_W = 5,
  localparam int INSN_W = 3 + 3*REG_W
) (
  input  logic [INSN_W-1:0] insn,
  output logic              is_ctl,
  output logic              is_prm,
  output logic              kind,
  output logic [REG_W-1:0]  f_rd,
  output logic [REG_W-1:0]  f_ra,
  output logic [REG_W-1:0]  f_rb
);
  import pbc_pkg::*;

  localparam int CLS_LSB  = 3*REG_W + 1;
  localparam int KIND_BIT = 3*REG_W;

  insn_cls_e cls;

  always_comb begin
    cls    = insn_cls_e'(insn[CLS_LSB +: 2]);
    is_ctl = (cls == CLS_CTL);
    is_prm = (cls == CLS_PRM);
    kind   = insn[KIND_BIT];
    f_rd   = insn[2*REG_W +: REG_W];
    f_ra   = insn[REG_W +: REG_W];
    f_rb   = insn[0 +: REG_W];
  end
endmodule

// File: rtl/pbc_hold.sv
module pbc_hold #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             clr,
  input  logic             drop,
  input  logic             d_kind,
  input  logic [REG_W-1:0] d_cfg1,
  input  logic [REG_W-1:0] d_cfg2,
  output logic             pend,
  output logic             p_kind,
  output logic [REG_W-1:0] p_cfg1,
  output logic [REG_W-1:0] p_cfg2,
  output logic             err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      err    <= 1'b0;
      p_kind <= 1'b0;
      p_cfg1 <= '0;
      p_cfg2 <= '0;
    end else begin
      err <= drop;
      if (cap) begin
        pend   <= 1'b1;
        p_kind <= d_kind;
        p_cfg1 <= d_cfg1;
        p_cfg2 <= d_cfg2;
      end else if (clr || drop) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pbc_pair.sv
module pbc_pair #(
  parameter int REG_W = 5
) (
  input  logic             in_valid,
  input  logic             iss_ready,
  input  logic             is_ctl,
  input  logic             is_prm,
  input  logic             kind,
  input  logic [REG_W-1:0] f_rd,
  input  logic [REG_W-1:0] f_ra,
  input  logic [REG_W-1:0] f_rb,
  input  logic             pend,
  input  logic             p_kind,
  input  logic [REG_W-1:0] p_cfg1,
  input  logic [REG_W-1:0] p_cfg2,
  output logic             in_ready,
  output logic             iss_valid,
  output logic             bundle,
  output logic [REG_W-1:0] o_rd,
  output logic [REG_W-1:0] o_rs0,
  output logic [REG_W-1:0] o_rs1,
  output logic [REG_W-1:0] o_rs2,
  output logic [REG_W-1:0] o_rs3,
  output logic [pbc_pkg::RD_PORTS-1:0] rden,
  output logic             cap,
  output logic             clr,
  output logic             drop
);
  import pbc_pkg::*;

  logic match;

  always_comb begin
    match     = pend && is_prm && (kind == p_kind);
    in_ready  = 1'b0;
    iss_valid = 1'b0;
    bundle    = 1'b0;
    cap       = 1'b0;
    clr       = 1'b0;
    drop      = 1'b0;
    o_rd      = f_rd;
    o_rs0     = f_ra;
    o_rs1     = f_rb;
    o_rs2     = '0;
    o_rs3     = '0;
    if (!pend) begin
      if (is_ctl) begin
        in_ready = 1'b1;
        cap      = in_valid;
      end else begin
        iss_valid = in_valid;
        in_ready  = iss_ready;
      end
    end else if (match) begin
      iss_valid = in_valid;
      in_ready  = iss_ready;
      bundle    = 1'b1;
      clr       = in_valid && iss_ready;
      o_rs1     = p_cfg1;
      o_rs2     = p_cfg2;
      o_rs3     = f_rb;
    end else begin
      drop = in_valid;
    end
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rden
    if (g < BASE_PORTS) begin : g_base
      assign rden[g] = iss_valid;
    end else begin : g_extra
      assign rden[g] = iss_valid && bundle;
    end
  end
endmodule

// File: rtl/perm_bundle_combiner.sv
module perm_bundle_combiner #(
  parameter int REG_W = 5,
  localparam int INSN_W = 3 + 3*REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic              iss_bundle,
  output logic              iss_inv,
  output logic [INSN_W-1:0] iss_insn,
  output logic [REG_W-1:0]  iss_rd,
  output logic [REG_W-1:0]  iss_rs0,
  output logic [REG_W-1:0]  iss_rs1,
  output logic [REG_W-1:0]  iss_rs2,
  output logic [REG_W-1:0]  iss_rs3,
  output logic [3:0]        iss_rden,
  output logic              orphan_err
);
  logic             is_ctl, is_prm, kind;
  logic [REG_W-1:0] f_rd, f_ra, f_rb;
  logic             pend_q, p_kind;
  logic [REG_W-1:0] p_cfg1, p_cfg2;
  logic             cap, clr, drop;

  pbc_decode #(.REG_W(REG_W)) u_dec (
    .insn(in_insn), .is_ctl(is_ctl), .is_prm(is_prm), .kind(kind),
    .f_rd(f_rd), .f_ra(f_ra), .f_rb(f_rb)
  );

  pbc_hold #(.REG_W(REG_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap(cap), .clr(clr), .drop(drop),
    .d_kind(kind), .d_cfg1(f_ra), .d_cfg2(f_rb),
    .pend(pend_q), .p_kind(p_kind), .p_cfg1(p_cfg1), .p_cfg2(p_cfg2),
    .err(orphan_err)
  );

  pbc_pair #(.REG_W(REG_W)) u_pair (
    .in_valid(in_valid), .iss_ready(iss_ready),
    .is_ctl(is_ctl), .is_prm(is_prm), .kind(kind),
    .f_rd(f_rd), .f_ra(f_ra), .f_rb(f_rb),
    .pend(pend_q), .p_kind(p_kind), .p_cfg1(p_cfg1), .p_cfg2(p_cfg2),
    .in_ready(in_ready), .iss_valid(iss_valid), .bundle(iss_bundle),
    .o_rd(iss_rd), .o_rs0(iss_rs0), .o_rs1(iss_rs1),
    .o_rs2(iss_rs2), .o_rs3(iss_rs3), .rden(iss_rden),
    .cap(cap), .clr(clr), .drop(drop)
  );

  assign iss_inv  = kind;
  assign iss_insn = in_insn;
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             iss_bundle,
  input logic             iss_inv,
  input logic [REG_W-1:0] iss_rs0,
  input logic             orphan_err,
  input logic             pend_q,
  input logic             p_kind
);
  assert_bundle_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_bundle) |-> (pend_q && iss_inv == p_kind));

  assert_err_after_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orphan_err) |-> $past(in_valid && !in_ready && pend_q));

  assert_capture_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !$past(pend_q)) |-> $past(in_valid && in_ready && !iss_valid));

  assert_issue_consumes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> (in_valid && in_ready));

  assert_stall_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_rs0)));
endmodule

bind perm_bundle_combiner pbc_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_bundle(iss_bundle),
  .iss_inv(iss_inv), .iss_rs0(iss_rs0), .orphan_err(orphan_err),
  .pend_q(pend_q), .p_kind(p_kind)
);

// File: tb/perm_bundle_combiner_tb.sv
module perm_bundle_combiner_tb;
  localparam int REG_W  = 5;
  localparam int INSN_W = 3 + 3*REG_W;
  localparam int NV     = 16;

  typedef struct packed {
    logic [3:0]        req;
    logic              vld;
    logic [INSN_W-1:0] insn;
    logic              rdy;
    logic              e_inr;
    logic              e_val;
    logic              e_bnd;
    logic [REG_W-1:0]  e_rd, e_s0, e_s1, e_s2, e_s3;
    logic              e_err;
  } vec_t;

  function automatic logic [INSN_W-1:0] mk(input logic [1:0] c, input logic k,
      input int d, input int a, input int b);
    return {c, k, REG_W'(d), REG_W'(a), REG_W'(b)};
  endfunction

  function automatic vec_t v(input int rq, input logic vl, input logic [INSN_W-1:0] i,
      input logic r, input logic ir, input logic ev, input logic eb,
      input int d, input int s0, input int s1, input int s2, input int s3, input logic er);
    vec_t t;
    t.req = 4'(rq); t.vld = vl; t.insn = i; t.rdy = r; t.e_inr = ir; t.e_val = ev;
    t.e_bnd = eb; t.e_rd = REG_W'(d); t.e_s0 = REG_W'(s0); t.e_s1 = REG_W'(s1);
    t.e_s2 = REG_W'(s2); t.e_s3 = REG_W'(s3); t.e_err = er;
    return t;
  endfunction

  // class 00 ordinary, 01 control, 10 permute; kind 0 forward, 1 inverse
  localparam vec_t VT [NV] = '{
    v(2,  1, mk(2'b00,0,1,2,3),  1, 1,1,0, 1,2,3,0,0, 0),   // R2 ordinary
    v(3,  1, mk(2'b01,0,0,4,5),  1, 1,0,0, 0,0,0,0,0, 0),   // R3 capture, R10 beat 1
    v(4,  1, mk(2'b10,0,6,7,8),  1, 1,1,1, 6,7,4,5,8, 0),   // R4 forward bundle, R10 beat 2
    v(10, 1, mk(2'b01,1,0,9,10), 1, 1,0,0, 0,0,0,0,0, 0),   // R10 beat 3
    v(10, 1, mk(2'b10,1,11,12,13),1,1,1,1, 11,12,9,10,13,0),// R4 inverse, R10 beat 4
    v(3,  1, mk(2'b01,0,0,1,2),  1, 1,0,0, 0,0,0,0,0, 0),   // R3
    v(5,  1, mk(2'b10,1,3,4,5),  1, 0,0,0, 0,0,0,0,0, 0),   // R5 kind mismatch refused
    v(7,  1, mk(2'b10,1,3,4,5),  1, 1,1,0, 3,4,5,0,0, 1),   // R6 strobe, R7 unpaired
    v(3,  1, mk(2'b01,1,0,6,7),  1, 1,0,0, 0,0,0,0,0, 0),   // R3
    v(9,  0, mk(2'b00,0,0,0,0),  1, 0,0,0, 0,0,0,0,0, 0),   // R9 idle while held
    v(6,  1, mk(2'b00,0,2,3,4),  1, 0,0,0, 0,0,0,0,0, 0),   // R6 ordinary after control
    v(6,  1, mk(2'b00,0,2,3,4),  1, 1,1,0, 2,3,4,0,0, 1),   // R6 strobe then pass
    v(3,  1, mk(2'b01,0,0,1,1),  1, 1,0,0, 0,0,0,0,0, 0),   // R3
    v(8,  1, mk(2'b10,0,2,3,4),  0, 0,1,1, 2,3,1,1,4, 0),   // R8 stalled bundle
    v(8,  1, mk(2'b10,0,2,3,4),  1, 1,1,1, 2,3,1,1,4, 0),   // R8 released
    v(2,  1, mk(2'b11,1,5,6,7),  1, 1,1,0, 5,6,7,0,0, 0)    // R2 class 11 ordinary
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, iss_ready = 1'b1;
  logic [INSN_W-1:0] in_insn = '0;
  logic in_ready, iss_valid, iss_bundle, iss_inv, orphan_err;
  logic [INSN_W-1:0] iss_insn;
  logic [REG_W-1:0] iss_rd, iss_rs0, iss_rs1, iss_rs2, iss_rs3;
  logic [3:0] iss_rden;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  perm_bundle_combiner #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_bundle(iss_bundle), .iss_inv(iss_inv), .iss_insn(iss_insn),
    .iss_rd(iss_rd), .iss_rs0(iss_rs0), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2),
    .iss_rs3(iss_rs3), .iss_rden(iss_rden), .orphan_err(orphan_err)
  );

  task automatic chk(input string what, input int rq, input logic [31:0] act,
      input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic vl, input logic [INSN_W-1:0] i, input logic r);
    @(negedge clk);
    in_valid = vl; in_insn = i; iss_ready = r;
    #2;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1 reset state
    drive(1'b0, '0, 1'b0);
    chk("reset iss_valid", 1, 32'(iss_valid), 0);
    chk("reset err", 1, 32'(orphan_err), 0);
    chk("reset in_ready", 1, 32'(in_ready), 0);
    rst_n = 1'b1;
    drive(1'b0, '0, 1'b1);
    chk("post-reset in_ready", 1, 32'(in_ready), 1);

    for (int k = 0; k < NV; k++) begin
      drive(VT[k].vld, VT[k].insn, VT[k].rdy);
      chk("in_ready", VT[k].req, 32'(in_ready), 32'(VT[k].e_inr));
      chk("iss_valid", VT[k].req, 32'(iss_valid), 32'(VT[k].e_val));
      chk("orphan_err", VT[k].req, 32'(orphan_err), 32'(VT[k].e_err));
      if (VT[k].e_val) begin
        chk("bundle", VT[k].req, 32'(iss_bundle), 32'(VT[k].e_bnd));
        chk("rd", VT[k].req, 32'(iss_rd), 32'(VT[k].e_rd));
        chk("rs0", VT[k].req, 32'(iss_rs0), 32'(VT[k].e_s0));
        chk("rs1", VT[k].req, 32'(iss_rs1), 32'(VT[k].e_s1));
        if (VT[k].e_bnd) begin
          chk("rs2", VT[k].req, 32'(iss_rs2), 32'(VT[k].e_s2));
          chk("rs3", VT[k].req, 32'(iss_rs3), 32'(VT[k].e_s3));
        end
        chk("rden", VT[k].req, 32'(iss_rden), VT[k].e_bnd ? 32'hF : 32'h3);
      end
    end

    // R6 strobe lasts one cycle only
    drive(1'b0, '0, 1'b1);
    chk("err single cycle", 6, 32'(orphan_err), 0);

    // R1 reset while a control is held discards it
    drive(1'b1, mk(2'b01,0,0,3,3), 1'b1);
    chk("capture before reset", 3, 32'(iss_valid), 0);
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, mk(2'b10,0,4,5,6), 1'b1);
    chk("permute after reset unpaired", 1, 32'(iss_bundle), 0);
    chk("permute after reset valid", 1, 32'(iss_valid), 1);
    chk("no err after reset", 1, 32'(orphan_err), 0);
    chk("ports after reset", 7, 32'(iss_rden), 32'h3);

    drive(1'b0, '0, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule